// File: doc/BRIEF.md
# Raster position IRQ trigger

This block decides the moment a programmable beam-position interrupt fires. Software programs a target line and a target dot, plus separate enables for line matching and dot matching. The beam position comes in as a line number and a cycle count within the line, counted in master-clock cycles. The block checks its trigger condition only when the CPU core signals an instruction boundary. It converts the dot target into a cycle threshold. That threshold includes the length of the last instruction cycle and a fixed pipeline offset, and it may roll over into the following line. Some target positions can never occur, and the block refuses to fire for them.

When the trigger fires, the block pulls an active-low IRQ line low and sets a sticky triggered flag. A read of the interrupt status register, signalled by a one-cycle strobe, clears both. All pins are plain control and status signals. The block has no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `raster_irq_trigger`

## Requirements
- R1: After reset, `irq_n` is 1 and `triggered` is 0.
- R2: The trigger is evaluated only in a cycle where `op_edge` is 1, `irq_mask` is 0 and `irq_n` is 1. A firing condition in any other cycle leaves both outputs unchanged.
- R3: When `v_en` and `h_en` are both 0, the block never fires.
- R4: The effective dot is `h_target` when `h_en` is 1, and 0 otherwise. For an effective dot of 0, the cycle threshold is `last_op_cyc + 14` and is never wrapped.
- R5: For a nonzero effective dot H, the raw threshold is `4*H + last_op_cyc + 18`. No correction is made for long dots.
- R6: If a nonzero-dot raw threshold is greater than or equal to the line length, the line length is subtracted from it and the target line becomes `v_target + 1`. If that line reaches the frame line count, the target line becomes 0.
- R7: The block never fires when the effective dot exceeds 339 or `v_target` exceeds 262. It also never fires when `v_target` is 262 with `interlace` = 0, or when `v_target` is 262 and the effective dot is 339.
- R8: The block never fires when `v_target` is 261 and the effective dot is 339 with `interlace` = 0. It also never fires when `v_target` is 240, the effective dot is 339, `interlace` = 0 and `odd_field` = 1.
- R9: With `v_en` = 1, a fire needs `vcount` to equal the adjusted target line and `hcycle` to be at least the threshold. With `v_en` = 0, `vcount` is ignored.
- R10: A fire makes `irq_n` 0 and `triggered` 1 at the clock edge that samples the evaluating strobe.
- R11: A `status_rd` pulse makes `irq_n` 1 and `triggered` 0 at the next edge. If a fire and `status_rd` occur in the same cycle, the fire wins. While `irq_n` is 0, evaluation is blocked, so the clear always takes effect.
- R12: `line_cycles` = 0 selects a line length of 1364. `frame_lines` = 0 selects 262 lines when `interlace` = 0 and 263 lines when `interlace` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_edge | input | 1 | Instruction-boundary strobe |
| irq_mask | input | 1 | CPU interrupt-disable flag |
| v_en | input | 1 | Enable line matching |
| h_en | input | 1 | Enable dot matching |
| v_target | input | 9 | Programmed target line |
| h_target | input | 9 | Programmed target dot |
| last_op_cyc | input | 4 | Master cycles in the last instruction cycle |
| line_cycles | input | 12 | Line length in master cycles (0 selects the default) |
| frame_lines | input | 9 | Lines per frame (0 selects the default) |
| interlace | input | 1 | Interlaced mode |
| odd_field | input | 1 | Current field is odd |
| vcount | input | 9 | Current beam line |
| hcycle | input | 12 | Current master-cycle position in the line |
| status_rd | input | 1 | Status-read strobe that acknowledges the interrupt |
| irq_n | output | 1 | Active-low interrupt request |
| triggered | output | 1 | Sticky triggered flag |

## Verification
The assertions check properties that hold on every cycle:
- any falling edge of `irq_n` traces back to an unmasked boundary strobe with an enable set and a position that is not rejected;
- the sampled cycle had reached the computed threshold;
- an acknowledge with no competing fire releases the line.

Only the bench's scenarios can show that the threshold arithmetic and the rollover into the next line land on the right cycle. The same holds for the forbidden-position list, the defaults, and the blocking of re-evaluation while the line is held low.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
  localparam int unsigned MAX_DOT       = 339;
  localparam int unsigned MAX_LINE      = 262;
  localparam int unsigned SHORT_LINE    = 261;
  localparam int unsigned FIELD_LINE    = 240;
  localparam int unsigned OFS_DOT_ZERO  = 14;
  localparam int unsigned OFS_DOT_OTHER = 18;
  localparam int unsigned DEF_LINE_CYC  = 1364;
  localparam int unsigned DEF_FRAME_P   = 262;
  localparam int unsigned DEF_FRAME_I   = 263;

  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_BLOCK = 2'd1,
    EV_FIRE  = 2'd2
  } eval_e;
endpackage

// File: rtl/rit_defaults.sv
module rit_defaults
  import raster_irq_pkg::*;
#(
  parameter int V_W   = 9,
  parameter int CYC_W = 12
) (
  input  logic [CYC_W-1:0] line_cycles,
  input  logic [V_W-1:0]   frame_lines,
  input  logic             interlace,
  output logic [CYC_W-1:0] line_len,
  output logic [V_W-1:0]   frame_len
);
  always_comb begin
    line_len = (line_cycles == '0) ? CYC_W'(DEF_LINE_CYC) : line_cycles;
    if (frame_lines != '0)
      frame_len = frame_lines;
    else if (interlace)
      frame_len = V_W'(DEF_FRAME_I);
    else
      frame_len = V_W'(DEF_FRAME_P);
  end
endmodule

// File: rtl/rit_reject.sv
module rit_reject
  import raster_irq_pkg::*;
#(
  parameter int V_W = 9,
  parameter int H_W = 9
) (
  input  logic [V_W-1:0] v_tgt,
  input  logic [H_W-1:0] h_eff,
  input  logic           interlace,
  input  logic           odd_field,
  output logic           reject
);
  logic dot_last, out_of_range, bad_last_line, bad_short_line, bad_field_line;

  always_comb begin
    dot_last       = (h_eff == H_W'(MAX_DOT));
    out_of_range   = (h_eff > H_W'(MAX_DOT)) || (v_tgt > V_W'(MAX_LINE));
    bad_last_line  = (v_tgt == V_W'(MAX_LINE)) && (!interlace || dot_last);
    bad_short_line = (v_tgt == V_W'(SHORT_LINE)) && dot_last && !interlace;
    bad_field_line = (v_tgt == V_W'(FIELD_LINE)) && dot_last && !interlace && odd_field;
    reject = out_of_range || bad_last_line || bad_short_line || bad_field_line;
  end
endmodule

// File: rtl/rit_threshold.sv
module rit_threshold
  import raster_irq_pkg::*;
#(
  parameter int V_W   = 9,
  parameter int H_W   = 9,
  parameter int CYC_W = 12,
  parameter int OP_W  = 4,
  localparam int TW   = CYC_W + 1
) (
  input  logic [H_W-1:0]   h_eff,
  input  logic [OP_W-1:0]  last_op_cyc,
  input  logic [CYC_W-1:0] line_len,
  input  logic [V_W-1:0]   v_tgt,
  input  logic [V_W-1:0]   frame_len,
  output logic [TW-1:0]    thr,
  output logic [V_W-1:0]   tgt_line
);
  logic [TW-1:0] raw;
  logic [V_W:0]  next_line;
  logic          wrap;

  always_comb begin
    if (h_eff == '0)
      raw = TW'(last_op_cyc) + TW'(OFS_DOT_ZERO);
    else
      raw = (TW'(h_eff) << 2) + TW'(last_op_cyc) + TW'(OFS_DOT_OTHER);
    wrap      = (h_eff != '0) && (raw >= TW'(line_len));
    thr       = wrap ? (raw - TW'(line_len)) : raw;
    next_line = {1'b0, v_tgt} + (V_W+1)'(1);
    if (!wrap)
      tgt_line = v_tgt;
    else if (next_line >= {1'b0, frame_len})
      tgt_line = '0;
    else
      tgt_line = next_line[V_W-1:0];
  end
endmodule

// File: rtl/rit_flag.sv
module rit_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clear,
  output logic irq_n,
  output logic triggered
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_n     <= 1'b1;
      triggered <= 1'b0;
    end else if (fire) begin
      irq_n     <= 1'b0;
      triggered <= 1'b1;
    end else if (clear) begin
      irq_n     <= 1'b1;
      triggered <= 1'b0;
    end
  end

  // R11
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !fire) |=> (irq_n && !triggered));

  // R10
  fire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!irq_n && triggered));
endmodule

// File: rtl/raster_irq_trigger.sv
module raster_irq_trigger
  import raster_irq_pkg::*;
#(
  parameter int V_W   = 9,
  parameter int H_W   = 9,
  parameter int CYC_W = 12,
  parameter int OP_W  = 4,
  localparam int TW   = CYC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_edge,
  input  logic             irq_mask,
  input  logic             v_en,
  input  logic             h_en,
  input  logic [V_W-1:0]   v_target,
  input  logic [H_W-1:0]   h_target,
  input  logic [OP_W-1:0]  last_op_cyc,
  input  logic [CYC_W-1:0] line_cycles,
  input  logic [V_W-1:0]   frame_lines,
  input  logic             interlace,
  input  logic             odd_field,
  input  logic [V_W-1:0]   vcount,
  input  logic [CYC_W-1:0] hcycle,
  input  logic             status_rd,
  output logic             irq_n,
  output logic             triggered
);
  logic [CYC_W-1:0] line_len;
  logic [V_W-1:0]   frame_len;
  logic [H_W-1:0]   h_eff;
  logic [TW-1:0]    thr;
  logic [V_W-1:0]   tgt_line;
  logic             reject;
  logic             line_ok, cycle_ok, fire;
  eval_e            ev_state;

  assign h_eff = h_en ? h_target : '0;

  rit_defaults #(.V_W(V_W), .CYC_W(CYC_W)) u_defaults (
    .line_cycles(line_cycles), .frame_lines(frame_lines), .interlace(interlace),
    .line_len(line_len), .frame_len(frame_len)
  );

  rit_reject #(.V_W(V_W), .H_W(H_W)) u_reject (
    .v_tgt(v_target), .h_eff(h_eff), .interlace(interlace),
    .odd_field(odd_field), .reject(reject)
  );

  rit_threshold #(.V_W(V_W), .H_W(H_W), .CYC_W(CYC_W), .OP_W(OP_W)) u_thr (
    .h_eff(h_eff), .last_op_cyc(last_op_cyc), .line_len(line_len),
    .v_tgt(v_target), .frame_len(frame_len), .thr(thr), .tgt_line(tgt_line)
  );

  always_comb begin
    line_ok  = !v_en || (vcount == tgt_line);
    cycle_ok = ({1'b0, hcycle} >= thr);
    if (!op_edge || irq_mask || !irq_n || !(v_en || h_en) || reject)
      ev_state = EV_BLOCK;
    else if (line_ok && cycle_ok)
      ev_state = EV_FIRE;
    else
      ev_state = EV_IDLE;
  end

  assign fire = (ev_state == EV_FIRE);

  rit_flag u_flag (
    .clk(clk), .rst_n(rst_n), .fire(fire), .clear(status_rd),
    .irq_n(irq_n), .triggered(triggered)
  );

  // R2
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(op_edge) && !$past(irq_mask)));

  // R3
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(v_en) || $past(h_en)));

  // R7
  reject_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> !$past(reject));

  // R9
  cycle_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past({1'b0, hcycle}) >= $past(thr)));
endmodule

// File: tb/raster_irq_trigger_tb.sv
module raster_irq_trigger_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_edge = 0, irq_mask = 0, v_en = 0, h_en = 0;
  logic [8:0]  v_target = 0, h_target = 0, frame_lines = 0, vcount = 0;
  logic [3:0]  last_op_cyc = 6;
  logic [11:0] line_cycles = 0, hcycle = 0;
  logic interlace = 0, odd_field = 0, status_rd = 0;
  logic irq_n, triggered;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_irq_trigger u_dut (
    .clk(clk), .rst_n(rst_n), .op_edge(op_edge), .irq_mask(irq_mask),
    .v_en(v_en), .h_en(h_en), .v_target(v_target), .h_target(h_target),
    .last_op_cyc(last_op_cyc), .line_cycles(line_cycles), .frame_lines(frame_lines),
    .interlace(interlace), .odd_field(odd_field), .vcount(vcount), .hcycle(hcycle),
    .status_rd(status_rd), .irq_n(irq_n), .triggered(triggered)
  );

  function automatic int eff_dot();
    return h_en ? int'(h_target) : 0;
  endfunction
  function automatic int len_now();
    return (line_cycles == 0) ? 1364 : int'(line_cycles);
  endfunction
  function automatic int lines_now();
    if (frame_lines != 0) return int'(frame_lines);
    return interlace ? 263 : 262;
  endfunction
  function automatic int raw_thr();
    int h = eff_dot();
    return (h == 0) ? int'(last_op_cyc) + 14 : 4*h + int'(last_op_cyc) + 18;
  endfunction
  function automatic bit wraps();
    return (eff_dot() != 0) && (raw_thr() >= len_now());
  endfunction
  function automatic int exp_thr();
    return wraps() ? raw_thr() - len_now() : raw_thr();
  endfunction
  function automatic int exp_line();
    int l = int'(v_target);
    if (!wraps()) return l;
    l = l + 1;
    return (l >= lines_now()) ? 0 : l;
  endfunction
  function automatic bit forbidden();
    int h = eff_dot();
    int v = int'(v_target);
    if (h > 339 || v > 262) return 1;
    if (v == 262 && (!interlace || h == 339)) return 1;
    if (v == 261 && h == 339 && !interlace) return 1;
    if (v == 240 && h == 339 && !interlace && odd_field) return 1;
    return 0;
  endfunction
  function automatic bit expect_fire();
    if (!op_edge || irq_mask) return 0;
    if (!v_en && !h_en) return 0;
    if (forbidden()) return 0;
    if (v_en && int'(vcount) != exp_line()) return 0;
    return int'(hcycle) >= exp_thr();
  endfunction

  task automatic check_out(input string tag, input bit e_irq_n, input bit e_trig);
    checks++;
    if (irq_n !== e_irq_n || triggered !== e_trig) begin
      errors++;
      $display("FAIL %s irq_n=%0b exp %0b triggered=%0b exp %0b", tag, irq_n, e_irq_n,
               triggered, e_trig);
    end
  endtask

  // Drive strobe at negedge, outputs update at the next posedge, sample at the following negedge.
  task automatic strobe_and_check(input string tag, input bit strobe);
    bit e;
    op_edge = strobe;
    e = expect_fire();
    @(negedge clk);
    op_edge = 0;
    check_out(tag, !e, e);
    if (e) begin
      status_rd = 1;
      @(negedge clk);
      status_rd = 0;
      check_out("R11 ack", 1'b1, 1'b0);
    end
  endtask

  task automatic set_hc(input int t);
    hcycle = (t < 0) ? 12'd0 : 12'(t);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dots[9] = '{0, 1, 2, 100, 300, 330, 335, 338, 339};
    int lasts[3] = '{6, 8, 12};
    repeat (3) @(negedge clk);
    check_out("R1 reset", 1'b1, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // R4 R5 R6 R9: line and dot matching sweep around the threshold
    v_en = 1; h_en = 1; v_target = 100;
    foreach (dots[i]) foreach (lasts[j])
      for (int d = -1; d <= 1; d++)
        for (int vm = 0; vm < 2; vm++) begin
          h_target = 9'(dots[i]); last_op_cyc = 4'(lasts[j]);
          set_hc(exp_thr() + d);
          vcount = 9'(vm ? exp_line() : exp_line() + 1);
          strobe_and_check((dots[i] == 0) ? "R4 dot0" : (wraps() ? "R6 wrap" : "R5 dotN"), 1);
        end

    // R4: vertical only, dot treated as 0
    h_en = 0; h_target = 200; vcount = 100; last_op_cyc = 6;
    for (int d = -1; d <= 1; d++) begin set_hc(20 + d); strobe_and_check("R4 vonly", 1); end

    // R9: dot only, line ignored
    v_en = 1; h_en = 1; h_target = 50; v_target = 10;
    v_en = 0;
    for (int vc = 0; vc < 262; vc += 37) begin
      vcount = 9'(vc);
      for (int d = -1; d <= 1; d++) begin set_hc(exp_thr() + d); strobe_and_check("R9 honly", 1); end
    end

    // R6: wrap to line 0 at the frame end
    v_en = 1; h_en = 1; v_target = 261; h_target = 338; last_op_cyc = 8;
    vcount = 0; set_hc(exp_thr()); strobe_and_check("R6 line0", 1);
    vcount = 262; strobe_and_check("R6 line0 miss", 1);
    interlace = 1; vcount = 262; set_hc(exp_thr()); strobe_and_check("R6 interlace", 1);
    interlace = 0;

    // R7 R8: forbidden positions, condition otherwise met
    h_en = 0; v_target = 262; vcount = 262; hcycle = 1000;
    strobe_and_check("R7 v262 prog", 1);
    interlace = 1; strobe_and_check("R7 v262 intl", 1);
    interlace = 0; v_en = 0; h_en = 1; h_target = 340; hcycle = 4000;
    strobe_and_check("R7 dot340", 1);
    v_en = 1; h_en = 0; v_target = 300; vcount = 300; hcycle = 1000;
    strobe_and_check("R7 v300", 1);
    h_en = 1; h_target = 339; last_op_cyc = 6;
    foreach (lasts[j]) begin
      last_op_cyc = 4'(lasts[j]);
      v_target = 262; interlace = 1; vcount = 9'(exp_line()); set_hc(exp_thr());
      strobe_and_check("R7 262/339", 1);
      v_target = 261; interlace = 0; vcount = 9'(exp_line()); set_hc(exp_thr());
      strobe_and_check("R8 261/339", 1);
      interlace = 1; vcount = 9'(exp_line()); strobe_and_check("R8 261 intl", 1);
      interlace = 0; v_target = 240; odd_field = 1; vcount = 9'(exp_line()); set_hc(exp_thr());
      strobe_and_check("R8 240 odd", 1);
      odd_field = 0; strobe_and_check("R8 240 even", 1);
    end

    // R3: both enables clear
    v_en = 0; h_en = 0; v_target = 5; vcount = 5; hcycle = 1300;
    strobe_and_check("R3 off", 1);

    // R2: no strobe, mask set
    v_en = 1; strobe_and_check("R2 nostrobe", 0);
    irq_mask = 1; strobe_and_check("R2 mask", 1);
    irq_mask = 0;

    // R12: explicit short line and frame counts against defaults
    h_en = 1; h_target = 300; v_target = 20; last_op_cyc = 6;
    line_cycles = 1200; frame_lines = 0;
    vcount = 9'(exp_line()); set_hc(exp_thr()); strobe_and_check("R12 short line", 1);
    line_cycles = 0; vcount = 9'(exp_line()); set_hc(exp_thr()); strobe_and_check("R12 default", 1);
    v_target = 262; interlace = 1; h_target = 338; frame_lines = 0;
    vcount = 9'(exp_line()); set_hc(exp_thr()); strobe_and_check("R12 frame263", 1);
    frame_lines = 9'd300; vcount = 9'(exp_line()); strobe_and_check("R12 frame300", 1);
    frame_lines = 0; interlace = 0;

    // R10 R11: while asserted, evaluation blocked so a coincident ack clears
    v_en = 1; h_en = 0; v_target = 50; vcount = 50; hcycle = 500;
    op_edge = 1; @(negedge clk); op_edge = 0;
    check_out("R10 fire", 1'b0, 1'b1);
    op_edge = 1; status_rd = 1; @(negedge clk); op_edge = 0; status_rd = 0;
    check_out("R11 blocked ack", 1'b1, 1'b0);
    op_edge = 1; status_rd = 1; @(negedge clk); op_edge = 0; status_rd = 0;
    check_out("R11 fire wins", 1'b0, 1'b1);
    status_rd = 1; @(negedge clk); status_rd = 0;
    check_out("R11 ack", 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule